// File: doc/BRIEF.md
# Display List Header Processor

This block programs a set of internal registers from descriptor lists held in memory, so that software does not have to write each register itself. Software places a header in memory and writes the header's byte address into the block. The block then reads the header, which names up to eight bodies. A body is a run of 8-byte entries, each a register address followed by a value. The block walks the bodies in order and sends one register write per entry on its write port.

When a list is finished, two flag bits in the header decide what happens next. The block can go straight on to a linked header, with no interrupt. It can raise a sticky interrupt and stop. Or it can raise the interrupt and wait for the next frame-start strobe, then run the linked header again. A header that links to itself therefore runs once per frame. If software writes a new header address while the block is busy, the address is held in a reference register. It replaces the linked header at the next frame start, so the block never switches lists in the middle of a frame.

Memory reads use a simple request/response port that has one read outstanding at a time. All addresses are byte addresses, and every read is one 32-bit word.

Top module: `dlist_hdr_proc`

## Requirements
- R1: After reset the status word (CSR offset 1) reads 0, `irq` is low, and the block makes no memory request and no register write.
- R2: Writing a header address to CSR offset 0 while idle starts processing at once. The header has five parts, each at a fixed word offset from the header address. The field at offset 0 holds the number of valid descriptors minus one, in bits 2:0. Descriptor i has its byte count at offset 4+8i and its body address at offset 8+8i. The next-header address is at offset 68. The flags word is at offset 72.
- R3: Each body entry is 8 bytes: the register address word, then the data word. Each entry produces exactly one write on `wr_valid`/`wr_addr`/`wr_data`, and entries are written in ascending memory order.
- R4: Bodies run strictly in descriptor order, from descriptor 0 up to the last valid descriptor.
- R5: A descriptor with a byte count of zero causes no reads of its body and no register writes.
- R6: If a list's flags have bit 0 set and bit 1 clear, the header at next-header is fetched and run at once, and no interrupt is raised for that list.
- R7: If a list's flags have bit 1 set and bit 0 clear, the sticky interrupt flag (status bit 1, also driven on `irq`) is set after the list's last write, and the block goes idle (status bit 0 clear).
- R8: If a list's flags have both bits set, the interrupt flag is set and the block stays busy until `frame_start`. It then runs the next-header list, so a header that links to itself repeats once per frame.
- R9: A header address written while busy sets status bit 2 (pending) and can be read back at CSR offset 0. At the next frame start it is used in place of the next-header address, and the pending bit clears.
- R10: Writing 1 to status bit 1 clears the interrupt flag. Writing 0 to that bit leaves the flag unchanged.
- R11: A body of 256 entries (byte count 2048) is executed in full.
- R12: If a list's flags have both bits clear, the block goes idle without raising the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CSR write strobe |
| cpu_addr | input | 2 | CSR offset: 0 = header address, 1 = status |
| cpu_wdata | input | 32 | CSR write data |
| cpu_rdata | output | 32 | Registered CSR read data for `cpu_addr` |
| irq | output | 1 | Sticky end-of-list interrupt |
| frame_start | input | 1 | Frame-start strobe |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 32 | Register address |
| wr_data | output | 32 | Register value |

## Verification
A wrong header walk shows up at once on the write port: a wrong offset, count or body order puts a mismatched address/value pair at the head of the scoreboard, on the first entry affected. A wrong flag decision shows up within a few cycles of the last write of a list. An early or missing `irq`, a busy bit stuck at the wrong value, or writes that appear without a frame strobe all show up there. A reference address that is lost or used too early shows up as the wrong list running after the frame strobe. A zero-length body that is not skipped shows up as reads of its address range.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HCNT,
    ST_HDESC,
    ST_HNEXT,
    ST_HFLAGS,
    ST_BSEL,
    ST_BLOAD,
    ST_BADDR,
    ST_BDATA,
    ST_FIN,
    ST_WAITF
  } eng_state_e;

  localparam int FLAG_AUTO = 0;
  localparam int FLAG_IRQ  = 1;

  localparam logic [1:0] CSR_HDR  = 2'd0;
  localparam logic [1:0] CSR_STAT = 2'd1;

  localparam int STAT_BUSY = 0;
  localparam int STAT_IRQ  = 1;
  localparam int STAT_PEND = 2;
endpackage

// File: rtl/dlp_desc_ram.sv
module dlp_desc_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 41
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/dlp_csr.sv
module dlp_csr
  import dlp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  input  logic          busy,
  input  logic          done_irq,
  input  logic          ref_take,
  output logic          start,
  output logic [AW-1:0] start_addr,
  output logic          ref_pend,
  output logic [AW-1:0] ref_addr
);
  logic hdr_wr, stat_clr;

  assign hdr_wr     = cpu_we && (cpu_addr == CSR_HDR);
  assign stat_clr   = cpu_we && (cpu_addr == CSR_STAT) && cpu_wdata[STAT_IRQ];
  assign start      = hdr_wr && !busy;
  assign start_addr = cpu_wdata[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      ref_pend  <= 1'b0;
      ref_addr  <= '0;
      cpu_rdata <= '0;
    end else begin
      if (done_irq)      irq <= 1'b1;
      else if (stat_clr) irq <= 1'b0;

      if (hdr_wr && busy) begin
        ref_addr <= cpu_wdata[AW-1:0];
        ref_pend <= 1'b1;
      end else if (ref_take) begin
        ref_pend <= 1'b0;
      end

      if (cpu_addr == CSR_HDR) begin
        cpu_rdata <= DW'(ref_addr);
      end else if (cpu_addr == CSR_STAT) begin
        cpu_rdata                <= '0;
        cpu_rdata[STAT_BUSY]     <= busy;
        cpu_rdata[STAT_IRQ]      <= irq;
        cpu_rdata[STAT_PEND]     <= ref_pend;
      end else begin
        cpu_rdata <= '0;
      end
    end
  end

  // R10: a write-one clear with no completion in the same cycle leaves the flag low
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !done_irq) |=> !irq);

  // R7: the flag only rises after the engine reports a completed list
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done_irq));

  // R9: a header write while busy leaves a pending reference
  assert_ref_latch_R9: assert property (@(posedge clk) disable iff (rst)
    (hdr_wr && busy) |=> ref_pend);
endmodule

// File: rtl/dlp_engine.sv
module dlp_engine
  import dlp_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int MAX_BODIES  = 8,
  parameter int MAX_ENTRIES = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          frame_start,
  input  logic          ref_pend,
  input  logic [AW-1:0] ref_addr,
  output logic          ref_take,
  output logic          done_irq,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          wr_valid,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int BW        = $clog2(MAX_BODIES);
  localparam int ENT_W     = $clog2(MAX_ENTRIES + 1);
  localparam int DESC_W    = ENT_W + AW;
  localparam int DESC_OFF  = 4;
  localparam int NEXT_OFF  = DESC_OFF + 8 * MAX_BODIES;
  localparam int FLAGS_OFF = NEXT_OFF + 4;

  eng_state_e        state;
  logic [AW-1:0]     cur_hdr, nxt_hdr, ptr, rd_addr_c;
  logic [BW-1:0]     hcnt, di, bi;
  logic              half, rd_pend, issue, read_state;
  logic [ENT_W-1:0]  tmp_ent, remain;
  logic [1:0]        flg;
  logic [DW-1:0]     ent_addr;
  logic              ram_we;
  logic [DESC_W-1:0] ram_q;
  logic [ENT_W-1:0]  ram_cnt;
  logic [AW-1:0]     ram_base;

  assign ram_cnt  = ram_q[DESC_W-1:AW];
  assign ram_base = ram_q[AW-1:0];
  assign ram_we   = (state == ST_HDESC) && mem_rvalid && half;

  dlp_desc_ram #(.DEPTH(MAX_BODIES), .W(DESC_W)) u_desc (
    .clk   (clk),
    .we    (ram_we),
    .waddr (di),
    .wdata ({tmp_ent, mem_rdata[AW-1:0]}),
    .raddr (bi),
    .rdata (ram_q)
  );

  assign busy     = (state != ST_IDLE);
  assign done_irq = (state == ST_FIN) && flg[FLAG_IRQ];
  assign ref_take = frame_start && ref_pend &&
                    ((state == ST_WAITF) || ((state == ST_IDLE) && !start));

  always_comb begin
    read_state = 1'b0;
    rd_addr_c  = cur_hdr;
    case (state)
      ST_HCNT:   begin read_state = 1'b1; rd_addr_c = cur_hdr; end
      ST_HDESC:  begin
        read_state = 1'b1;
        rd_addr_c  = cur_hdr + AW'(DESC_OFF) + AW'({di, 3'b000}) + (half ? AW'(4) : AW'(0));
      end
      ST_HNEXT:  begin read_state = 1'b1; rd_addr_c = cur_hdr + AW'(NEXT_OFF); end
      ST_HFLAGS: begin read_state = 1'b1; rd_addr_c = cur_hdr + AW'(FLAGS_OFF); end
      ST_BADDR:  begin read_state = 1'b1; rd_addr_c = ptr; end
      ST_BDATA:  begin read_state = 1'b1; rd_addr_c = ptr + AW'(4); end
      default:   begin read_state = 1'b0; rd_addr_c = cur_hdr; end
    endcase
  end

  assign issue = read_state && !rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_hdr  <= '0;
      nxt_hdr  <= '0;
      ptr      <= '0;
      hcnt     <= '0;
      di       <= '0;
      bi       <= '0;
      half     <= 1'b0;
      rd_pend  <= 1'b0;
      tmp_ent  <= '0;
      remain   <= '0;
      flg      <= '0;
      ent_addr <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      mem_req  <= 1'b0;
      wr_valid <= 1'b0;
      if (issue) begin
        mem_req  <= 1'b1;
        mem_addr <= rd_addr_c;
        rd_pend  <= 1'b1;
      end
      if (mem_rvalid) rd_pend <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (start) begin
            cur_hdr <= start_addr;
            state   <= ST_HCNT;
          end else if (frame_start && ref_pend) begin
            cur_hdr <= ref_addr;
            state   <= ST_HCNT;
          end
        end
        ST_HCNT: if (mem_rvalid) begin
          hcnt  <= mem_rdata[BW-1:0];
          di    <= '0;
          half  <= 1'b0;
          state <= ST_HDESC;
        end
        ST_HDESC: if (mem_rvalid) begin
          if (!half) begin
            tmp_ent <= mem_rdata[ENT_W+2:3];
            half    <= 1'b1;
          end else begin
            half <= 1'b0;
            if (di == hcnt) state <= ST_HNEXT;
            else            di    <= di + BW'(1);
          end
        end
        ST_HNEXT: if (mem_rvalid) begin
          nxt_hdr <= mem_rdata[AW-1:0];
          state   <= ST_HFLAGS;
        end
        ST_HFLAGS: if (mem_rvalid) begin
          flg   <= mem_rdata[1:0];
          bi    <= '0;
          state <= ST_BSEL;
        end
        ST_BSEL: state <= ST_BLOAD;
        ST_BLOAD: begin
          if (ram_cnt == '0) begin
            if (bi == hcnt) state <= ST_FIN;
            else begin
              bi    <= bi + BW'(1);
              state <= ST_BSEL;
            end
          end else begin
            ptr    <= ram_base;
            remain <= ram_cnt;
            state  <= ST_BADDR;
          end
        end
        ST_BADDR: if (mem_rvalid) begin
          ent_addr <= mem_rdata;
          state    <= ST_BDATA;
        end
        ST_BDATA: if (mem_rvalid) begin
          wr_valid <= 1'b1;
          wr_addr  <= ent_addr;
          wr_data  <= mem_rdata;
          ptr      <= ptr + AW'(8);
          remain   <= remain - ENT_W'(1);
          if (remain == ENT_W'(1)) begin
            if (bi == hcnt) state <= ST_FIN;
            else begin
              bi    <= bi + BW'(1);
              state <= ST_BSEL;
            end
          end else begin
            state <= ST_BADDR;
          end
        end
        ST_FIN: begin
          if (flg[FLAG_AUTO] && !flg[FLAG_IRQ]) begin
            cur_hdr <= nxt_hdr;
            state   <= ST_HCNT;
          end else if (flg[FLAG_AUTO]) begin
            state <= ST_WAITF;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WAITF: if (frame_start) begin
          cur_hdr <= ref_pend ? ref_addr : nxt_hdr;
          state   <= ST_HCNT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the memory port only sees a response for a read the engine has issued
  assert_resp_matches_req_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> rd_pend);

  // R3: register writes appear only while a list is being processed
  assert_write_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy);

  // R5: an empty descriptor is followed by no memory read
  assert_empty_body_no_read_R5: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_BLOAD) && (ram_cnt == '0)) |=> !mem_req);

  // R1: no reads are issued while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !mem_req);
endmodule

// File: rtl/dlist_hdr_proc.sv
module dlist_hdr_proc #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int MAX_BODIES  = 8,
  parameter int MAX_ENTRIES = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  input  logic          frame_start,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          wr_valid,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          start, ref_pend, ref_take, done_irq, busy;
  logic [AW-1:0] start_addr, ref_addr;

  dlp_csr #(.AW(AW), .DW(DW)) u_csr (
    .clk        (clk),
    .rst        (rst),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .irq        (irq),
    .busy       (busy),
    .done_irq   (done_irq),
    .ref_take   (ref_take),
    .start      (start),
    .start_addr (start_addr),
    .ref_pend   (ref_pend),
    .ref_addr   (ref_addr)
  );

  dlp_engine #(
    .AW(AW), .DW(DW), .MAX_BODIES(MAX_BODIES), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_addr  (start_addr),
    .frame_start (frame_start),
    .ref_pend    (ref_pend),
    .ref_addr    (ref_addr),
    .ref_take    (ref_take),
    .done_irq    (done_irq),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );
endmodule

// File: tb/dlist_hdr_proc_tb.sv
module dlist_hdr_proc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_addr = 2'd0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq;
  logic        frame_start = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        wr_valid;
  logic [31:0] wr_addr, wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlist_hdr_proc u_dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .frame_start(frame_start), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // memory model: three-cycle read latency
  logic [31:0] mem [0:4095];
  logic        p1_v = 1'b0, p2_v = 1'b0;
  logic [31:0] p1_a = '0, p2_a = '0;
  always @(posedge clk) begin
    p1_v <= mem_req;  p1_a <= mem_addr;
    p2_v <= p1_v;     p2_a <= p1_a;
    mem_rvalid <= p2_v;
    mem_rdata  <= mem[p2_a[13:2]];
  end

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  logic quiet = 1'b0;
  int zero_hits = 0;
  logic [31:0] zero_lo = 32'hFFFF_FFFF;

  typedef struct packed { logic [31:0] a; logic [31:0] d; } exp_t;
  exp_t q[$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: compare every register write against the scoreboard
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL %s unexpected write actual=%h/%h expected=none", cur_req, wr_addr, wr_data);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({cur_req, " R3 addr"}, wr_addr, e.a);
        chk({cur_req, " R3 data"}, wr_data, e.d);
        if (quiet) chk("R6 no irq mid-chain", {31'b0, irq}, 32'd0);
      end
    end
    if (!rst && mem_req && mem_addr >= zero_lo && mem_addr < zero_lo + 32'd64) zero_hits++;
  end

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    mem[a[13:2]] = d;
  endtask

  task automatic mk_hdr(input logic [31:0] h, input logic [31:0] cnt_m1,
                        input logic [31:0] nxt, input logic [31:0] flags);
    put(h, cnt_m1);
    put(h + 32'd68, nxt);
    put(h + 32'd72, flags);
  endtask

  task automatic mk_desc(input logic [31:0] h, input int i, input logic [31:0] bytes,
                         input logic [31:0] base);
    put(h + 32'd4 + 32'(8*i), bytes);
    put(h + 32'd8 + 32'(8*i), base);
  endtask

  task automatic mk_body(input logic [31:0] base, input int n, input int tag);
    for (int k = 0; k < n; k++) begin
      put(base + 32'(8*k), 32'hA000_0000 | 32'(tag << 12) | 32'(k*4));
      put(base + 32'(8*k) + 32'd4, 32'h5A5A_0000 ^ 32'(tag << 20) ^ 32'(k*7));
    end
  endtask

  task automatic push_body(input logic [31:0] base, input int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.a = mem[(base + 32'(8*k)) >> 2];
      e.d = mem[(base + 32'(8*k) + 32'd4) >> 2];
      q.push_back(e);
    end
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    v = cpu_rdata;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk({cur_req, " scoreboard empty"}, 32'(q.size()), 32'd0);
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cur_req = "R1";
    csr_rd(2'd1, v);
    chk("R1 status", v, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 no write", {31'b0, wr_valid}, 32'd0);

    // R2 R3 R7: single body, interrupt only
    cur_req = "R2";
    mk_hdr(32'h100, 32'd0, 32'h0, 32'd2);
    mk_desc(32'h100, 0, 32'd24, 32'h1000);
    mk_body(32'h1000, 3, 1);
    push_body(32'h1000, 3);
    csr_wr(2'd0, 32'h100);
    drain();
    chk("R7 irq set", {31'b0, irq}, 32'd1);
    csr_rd(2'd1, v);
    chk("R7 idle with irq", v, 32'h2);

    // R10: write 0 keeps flag, write 1 clears
    cur_req = "R10";
    csr_wr(2'd1, 32'h0);
    csr_rd(2'd1, v);
    chk("R10 write0 keeps", v, 32'h2);
    csr_wr(2'd1, 32'h2);
    csr_rd(2'd1, v);
    chk("R10 write1 clears", v, 32'h0);
    chk("R10 irq pin", {31'b0, irq}, 32'd0);

    // R4 R5: three descriptors, middle one empty
    cur_req = "R4";
    mk_hdr(32'h200, 32'd2, 32'h0, 32'd2);
    mk_desc(32'h200, 0, 32'd16, 32'h1100);
    mk_desc(32'h200, 1, 32'd0, 32'h1200);
    mk_desc(32'h200, 2, 32'd8, 32'h1300);
    mk_body(32'h1100, 2, 2);
    mk_body(32'h1200, 4, 15);
    mk_body(32'h1300, 1, 3);
    zero_lo = 32'h1200;
    push_body(32'h1100, 2);
    push_body(32'h1300, 1);
    csr_wr(2'd0, 32'h200);
    drain();
    chk("R5 empty body reads", 32'(zero_hits), 32'd0);
    csr_wr(2'd1, 32'h2);

    // R6: chain A (auto) -> B (irq)
    cur_req = "R6";
    mk_hdr(32'h300, 32'd0, 32'h380, 32'd1);
    mk_desc(32'h300, 0, 32'd16, 32'h1400);
    mk_body(32'h1400, 2, 4);
    mk_hdr(32'h380, 32'd0, 32'h0, 32'd2);
    mk_desc(32'h380, 0, 32'd8, 32'h1500);
    mk_body(32'h1500, 1, 5);
    push_body(32'h1400, 2);
    push_body(32'h1500, 1);
    quiet = 1'b1;
    csr_wr(2'd0, 32'h300);
    drain();
    quiet = 1'b0;
    chk("R6 irq at chain end", {31'b0, irq}, 32'd1);
    csr_wr(2'd1, 32'h2);

    // R12: no flags
    cur_req = "R12";
    mk_hdr(32'h400, 32'd0, 32'h0, 32'd0);
    mk_desc(32'h400, 0, 32'd8, 32'h1600);
    mk_body(32'h1600, 1, 6);
    push_body(32'h1600, 1);
    csr_wr(2'd0, 32'h400);
    drain();
    csr_rd(2'd1, v);
    chk("R12 idle no irq", v, 32'h0);

    // R8: continuous self-loop
    cur_req = "R8";
    mk_hdr(32'h500, 32'd0, 32'h500, 32'd3);
    mk_desc(32'h500, 0, 32'd16, 32'h1700);
    mk_body(32'h1700, 2, 7);
    push_body(32'h1700, 2);
    csr_wr(2'd0, 32'h500);
    drain();
    csr_rd(2'd1, v);
    chk("R8 waiting busy+irq", v, 32'h3);
    csr_wr(2'd1, 32'h2);
    push_body(32'h1700, 2);
    pulse_frame();
    drain();
    csr_rd(2'd1, v);
    chk("R8 second frame", v, 32'h3);
    csr_wr(2'd1, 32'h2);

    // R9: new header while busy, applied at frame start
    cur_req = "R9";
    mk_hdr(32'h600, 32'd0, 32'h0, 32'd2);
    mk_desc(32'h600, 0, 32'd8, 32'h1800);
    mk_body(32'h1800, 1, 8);
    csr_wr(2'd0, 32'h600);
    csr_rd(2'd1, v);
    chk("R9 pending set", v, 32'h5);
    csr_rd(2'd0, v);
    chk("R9 reference readback", v, 32'h600);
    repeat (30) @(negedge clk);
    chk("R9 no run before frame", 32'(q.size()), 32'd0);
    push_body(32'h1800, 1);
    pulse_frame();
    drain();
    csr_rd(2'd1, v);
    chk("R9 pending consumed, idle", v, 32'h2);
    csr_wr(2'd1, 32'h2);

    // R11: 256-entry body
    cur_req = "R11";
    mk_hdr(32'h700, 32'd0, 32'h0, 32'd2);
    mk_desc(32'h700, 0, 32'd2048, 32'h2000);
    mk_body(32'h2000, 256, 9);
    push_body(32'h2000, 256);
    csr_wr(2'd0, 32'h700);
    drain();
    chk("R11 irq after full body", {31'b0, irq}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule